// File: doc/BRIEF.md
# Link Alignment Supervisor with Bounded Retry

This block watches a 10 Gb link through two status inputs: a link-up flag and a lane-alignment flag. When a check strobe arrives and both flags are high, it reports the link as up. When either flag is low, it pulses a link-reset output and starts recovery. Recovery waits a fixed settle time and then samples the status. It repeats the wait-and-sample a bounded number of times per reset, and re-issues the reset a bounded number of times. Recovery ends as soon as the link is good.

The same check strobe also drives a bad-link detector. This detector compares two fault event counters, one for local faults and one for remote faults, against the values it captured at the previous check. It raises a flag when either counter has climbed too far in between.

Top module: `lnk_align_sup`

## Requirements
- R1: After reset, `link_rst`, `link_up` and `bad_link` are all 0.
- R2: A check accepted while idle, with `stat_up` and `stat_aligned` both 1, drives `link_up` to 1 on the following cycle and issues no reset pulse.
- R3: A check accepted while idle, with either status input 0, drives `link_rst` high for exactly one cycle on the following cycle and clears `link_up` in that same cycle.
- R4: Each status sample is taken SETTLE_CYC cycles after the preceding reset or sample. If the n-th sample (counting from 1) finds both statuses high, `link_up` rises exactly n*SETTLE_CYC cycles after the accepting clock edge, and no further reset pulse follows.
- R5: Each reset is followed by up to MAX_TRY samples. After MAX_TRY failed samples the reset is re-issued. At most MAX_TRY reset pulses are issued per recovery.
- R6: If all MAX_TRY*MAX_TRY samples fail, `link_up` stays 0 and the block returns to idle, where the next check is accepted again.
- R7: At each check, `bad_link` becomes 1 when either fault counter is strictly greater than its previously captured value plus 250; otherwise it becomes 0. The sum is computed in unsigned 32-bit arithmetic and wraps.
- R8: Both captured counter values are replaced at every check, whether or not `bad_link` was raised.
- R9: Between checks, `bad_link` holds its value. While idle, `link_up` holds its value. A check strobe that arrives during recovery starts no new reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stat_up | input | 1 | Link-up status from the PCS |
| stat_aligned | input | 1 | Lane-alignment status from the PCS |
| chk_stb | input | 1 | Periodic check strobe |
| lf_cnt | input | 32 | Local-fault event counter |
| rf_cnt | input | 32 | Remote-fault event counter |
| link_rst | output | 1 | One-cycle link-reset pulse |
| link_up | output | 1 | Reported link state |
| bad_link | output | 1 | Fault counters rose too fast since the previous check |

## Verification
The bound checker verifies the following on every cycle:
- every reset pulse lasts one cycle;
- an accepted check gives the correct immediate response, either link up or a reset pulse;
- `link_up` only rises on a good status sample;
- the number of reset pulses in one recovery never exceeds MAX_TRY;
- the outputs hold between checks.

Some behaviour can only be shown by the bench scenarios. These include the exact cycle at which a late success is seen, the reset counts for success at each sample index, and the return to idle after total failure. They also include the fault-counter threshold at 250 versus 251, wrapped sums, and the capture of the counter values after a flagged check.

// File: rtl/lnk_align_pkg.sv
// Shared types and helpers for the link alignment supervisor.
package lnk_align_pkg;

    // Recovery controller state.
    typedef enum logic {
        SUP_IDLE   = 1'b0,
        SUP_SETTLE = 1'b1
    } sup_state_t;

    // Width of the fault event counters.
    localparam int FLT_CNT_W = 32;

    // The link counts as good only with both status flags high.
    function automatic logic link_is_good(input logic up, input logic aligned);
        return up & aligned;
    endfunction

endpackage

// File: rtl/lnk_settle_timer.sv
// Settle timer.
// Counts cycles from the last restart and flags the cycle in which
// SETTLE_CYC cycles have passed. Assumes SETTLE_CYC >= 1. The count saturates
// at the terminal value until the next restart.
module lnk_settle_timer #(
    parameter int SETTLE_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);
    localparam int TW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(SETTLE_CYC - 1);

    logic [TW-1:0] cnt_q;

    // Terminal count reached.
    assign expired = (cnt_q == LAST);

    // Count up from the last restart, holding at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lnk_retry_ctl.sv
// Recovery controller.
// On an accepted check it either reports the link up or starts recovery.
// Recovery pulses a reset, then samples the status every settle period:
// up to MAX_TRY samples per reset, and up to MAX_TRY resets in total.
// Assumes MAX_TRY >= 1. Checks are ignored while recovery runs.
module lnk_retry_ctl
    import lnk_align_pkg::*;
#(
    parameter int MAX_TRY = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chk_stb,
    input  logic stat_up,
    input  logic stat_aligned,
    input  logic settle_done,
    output logic timer_restart,
    output logic link_rst,
    output logic link_up,
    output logic busy
);
    localparam int TW = $clog2(MAX_TRY + 1);
    localparam logic [TW-1:0] TRY_LIM = TW'(MAX_TRY);

    sup_state_t    state_q;
    logic [TW-1:0] inner_q;
    logic [TW-1:0] outer_q;
    logic          good;

    // Current link quality.
    assign good = link_is_good(stat_up, stat_aligned);

    // Hold the timer at zero while idle, and rearm it after each sample.
    assign timer_restart = (state_q == SUP_IDLE) || settle_done;

    // Recovery is in progress.
    assign busy = (state_q == SUP_SETTLE);

    // State, retry counters and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SUP_IDLE;
            inner_q  <= '0;
            outer_q  <= '0;
            link_rst <= 1'b0;
            link_up  <= 1'b0;
        end else begin
            link_rst <= 1'b0;
            case (state_q)
                SUP_IDLE: begin
                    if (chk_stb) begin
                        if (good) begin
                            link_up <= 1'b1;
                        end else begin
                            link_up  <= 1'b0;
                            link_rst <= 1'b1;
                            inner_q  <= TW'(1);
                            outer_q  <= TW'(1);
                            state_q  <= SUP_SETTLE;
                        end
                    end
                end
                SUP_SETTLE: begin
                    if (settle_done) begin
                        if (good) begin
                            link_up <= 1'b1;
                            state_q <= SUP_IDLE;
                        end else if (inner_q < TRY_LIM) begin
                            inner_q <= inner_q + 1'b1;
                        end else if (outer_q < TRY_LIM) begin
                            outer_q  <= outer_q + 1'b1;
                            inner_q  <= TW'(1);
                            link_rst <= 1'b1;
                        end else begin
                            state_q <= SUP_IDLE;
                        end
                    end
                end
                default: state_q <= SUP_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lnk_fault_watch.sv
// Fault-rate watcher.
// At each check, compares every fault counter with the value captured at
// the previous check plus JUMP (modular CW-bit sum, strict greater-than).
// It then captures the new values. The flag holds between checks.
module lnk_fault_watch #(
    parameter int NUM_CH = 2,
    parameter int CW     = 32,
    parameter int JUMP   = 250
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      chk_stb,
    input  logic [NUM_CH-1:0][CW-1:0] cnt_in,
    output logic                      bad_link
);
    logic [NUM_CH-1:0] over;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [CW-1:0] last_q;
        logic [CW-1:0] lim;

        // Largest value allowed without a flag.
        assign lim     = last_q + CW'(JUMP);
        assign over[g] = (cnt_in[g] > lim);

        // Capture the counter at every check.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                last_q <= '0;
            end else if (chk_stb) begin
                last_q <= cnt_in[g];
            end
        end
    end

    // Flag update, once per check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_link <= 1'b0;
        end else if (chk_stb) begin
            bad_link <= |over;
        end
    end
endmodule

// File: rtl/lnk_align_sup.sv
// Link alignment supervisor (top).
// Joins the recovery controller, its settle timer and the fault-rate watcher.
// Assumes the status inputs are already synchronous to clk.
module lnk_align_sup
    import lnk_align_pkg::*;
#(
    parameter int SETTLE_CYC = 1000,
    parameter int MAX_TRY    = 5,
    parameter int FLT_JUMP   = 250
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stat_up,
    input  logic                 stat_aligned,
    input  logic                 chk_stb,
    input  logic [FLT_CNT_W-1:0] lf_cnt,
    input  logic [FLT_CNT_W-1:0] rf_cnt,
    output logic                 link_rst,
    output logic                 link_up,
    output logic                 bad_link
);
    logic settle_done;
    logic timer_restart;
    logic recov_act;
    logic [1:0][FLT_CNT_W-1:0] flt_vec;

    // Group the two fault counters for the watcher.
    assign flt_vec = {rf_cnt, lf_cnt};

    lnk_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (timer_restart),
        .expired (settle_done)
    );

    lnk_retry_ctl #(.MAX_TRY(MAX_TRY)) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .chk_stb       (chk_stb),
        .stat_up       (stat_up),
        .stat_aligned  (stat_aligned),
        .settle_done   (settle_done),
        .timer_restart (timer_restart),
        .link_rst      (link_rst),
        .link_up       (link_up),
        .busy          (recov_act)
    );

    lnk_fault_watch #(.NUM_CH(2), .CW(FLT_CNT_W), .JUMP(FLT_JUMP)) u_flt (
        .clk      (clk),
        .rst_n    (rst_n),
        .chk_stb  (chk_stb),
        .cnt_in   (flt_vec),
        .bad_link (bad_link)
    );
endmodule

// File: rtl/lnk_align_chk.sv
// Assertion checker for lnk_align_sup, attached by bind.
// Observes the ports plus the recovery-active signal of the top.
module lnk_align_chk #(
    parameter int MAX_TRY = 5
) (
    input logic clk,
    input logic rst_n,
    input logic chk_stb,
    input logic stat_up,
    input logic stat_aligned,
    input logic link_rst,
    input logic link_up,
    input logic bad_link,
    input logic recov_act
);
    localparam int PW = $clog2(MAX_TRY + 2) + 1;

    logic [PW-1:0] pulses_q;
    logic          accept;

    assign accept = chk_stb && !recov_act;

    // Count reset pulses since the last accepted check.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            pulses_q <= '0;
        end else if (link_rst) begin
            pulses_q <= pulses_q + 1'b1;
        end
    end

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        link_rst |=> !link_rst);

    a_r2_good_check: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && stat_up && stat_aligned) |=> (link_up && !link_rst));

    a_r3_bad_check: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !(stat_up && stat_aligned)) |=> (link_rst && !link_up));

    a_r4_rise_on_good: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> $past(stat_up && stat_aligned));

    a_r5_reset_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pulses_q <= PW'(MAX_TRY));

    a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_stb |=> $stable(bad_link));

    a_r9_up_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_stb && !recov_act) |=> $stable(link_up));
endmodule

bind lnk_align_sup lnk_align_chk #(.MAX_TRY(MAX_TRY)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chk_stb      (chk_stb),
    .stat_up      (stat_up),
    .stat_aligned (stat_aligned),
    .link_rst     (link_rst),
    .link_up      (link_up),
    .bad_link     (bad_link),
    .recov_act    (recov_act)
);

// File: tb/lnk_align_sup_bench.sv
// Bench for lnk_align_sup: directed corners plus seeded random stimulus.
module lnk_align_sup_bench;
    localparam int CLK_P  = 10;
    localparam int SETTLE = 8;
    localparam int TRIES  = 3;
    localparam int JUMP   = 250;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stat_up = 1'b0;
    logic        stat_aligned = 1'b0;
    logic        chk_stb = 1'b0;
    logic [31:0] lf_cnt = '0;
    logic [31:0] rf_cnt = '0;
    logic        link_rst;
    logic        link_up;
    logic        bad_link;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [31:0] last_lf = '0;
    logic [31:0] last_rf = '0;

    always #(CLK_P/2) clk = ~clk;

    lnk_align_sup #(.SETTLE_CYC(SETTLE), .MAX_TRY(TRIES), .FLT_JUMP(JUMP)) u_lnk_align_sup (
        .clk(clk), .rst_n(rst_n), .stat_up(stat_up), .stat_aligned(stat_aligned),
        .chk_stb(chk_stb), .lf_cnt(lf_cnt), .rf_cnt(rf_cnt),
        .link_rst(link_rst), .link_up(link_up), .bad_link(bad_link)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected flag from the requirement: strict compare against the wrapped sum.
    function automatic bit exp_bad(input logic [31:0] lf, input logic [31:0] rf,
                                   input logic [31:0] plf, input logic [31:0] prf);
        logic [31:0] ll;
        logic [31:0] lr;
        ll = plf + 32'(JUMP);
        lr = prf + 32'(JUMP);
        return (lf > ll) || (rf > lr);
    endfunction

    // One fault check with good link status; checks the flag and that it holds.
    task automatic fault_check(input logic [31:0] lf, input logic [31:0] rf, input string tag);
        bit e;
        e = exp_bad(lf, rf, last_lf, last_rf);
        @(negedge clk);
        stat_up = 1'b1; stat_aligned = 1'b1;
        lf_cnt = lf; rf_cnt = rf; chk_stb = 1'b1;
        @(negedge clk);
        chk_stb = 1'b0;
        last_lf = lf; last_rf = rf;
        check(bad_link == e, tag, int'(bad_link), int'(e));
        repeat (3) @(negedge clk);
        check(bad_link == e, "R9 bad_link holds between checks", int'(bad_link), int'(e));
    endtask

    // Recovery run: the status turns good just before sample succ (0 = never).
    task automatic recover(input int succ, input bit up_not_al, input bit poke, input string tag);
        int pulses = 0;
        int rise = 0;
        int e_pulses;
        int e_rise;
        @(negedge clk);
        stat_up = up_not_al; stat_aligned = !up_not_al; chk_stb = 1'b1;
        for (int c = 1; c <= TRIES*TRIES*SETTLE + 8; c++) begin
            @(negedge clk);
            if (link_rst) pulses++;
            if (link_up && rise == 0) rise = c;
            if (c == 1) begin
                chk_stb = 1'b0;
                check(link_rst && !link_up, {tag, " R3 reset pulse, link down"},
                      int'({link_rst, link_up}), 2);
            end
            if (c == 2) check(!link_rst, {tag, " R3 pulse one cycle"}, int'(link_rst), 0);
            if (poke && c == 5) chk_stb = 1'b1;
            if (poke && c == 6) chk_stb = 1'b0;
            if (succ != 0 && c == succ*SETTLE) begin
                stat_up = 1'b1; stat_aligned = 1'b1;
            end
        end
        e_pulses = (succ == 0) ? TRIES : (succ - 1) / TRIES + 1;
        e_rise   = (succ == 0) ? 0 : succ * SETTLE + 1;
        check(pulses == e_pulses, {tag, " R5 reset pulse count"}, pulses, e_pulses);
        check(rise == e_rise, {tag, " R4 link_up rise cycle"}, rise, e_rise);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!link_rst && !link_up && !bad_link, "R1 outputs during reset",
              int'({link_rst, link_up, bad_link}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!link_rst && !link_up && !bad_link, "R1 outputs after reset",
              int'({link_rst, link_up, bad_link}), 0);

        // R2: good check.
        stat_up = 1'b1; stat_aligned = 1'b1; chk_stb = 1'b1;
        @(negedge clk);
        chk_stb = 1'b0;
        check(link_up && !link_rst, "R2 good check", int'({link_up, link_rst}), 2);
        repeat (4) @(negedge clk);
        check(link_up, "R9 link_up holds while idle", int'(link_up), 1);

        // R3/R4/R5: directed recovery cases.
        recover(1, 1'b1, 1'b0, "up-unaligned first sample");
        recover(TRIES, 1'b0, 1'b0, "aligned-only last inner");
        recover(TRIES + 1, 1'b1, 1'b0, "first of second reset");
        recover(TRIES*TRIES, 1'b1, 1'b0, "very last sample");
        // R9: a check strobe during recovery adds no reset.
        recover(TRIES + 2, 1'b1, 1'b1, "R9 strobe mid-recovery");
        // R6: total failure, then idle again.
        recover(0, 1'b1, 1'b0, "R6 all fail");
        check(!link_up, "R6 link stays down", int'(link_up), 0);
        @(negedge clk);
        stat_up = 1'b1; stat_aligned = 1'b1; chk_stb = 1'b1;
        @(negedge clk);
        chk_stb = 1'b0;
        check(link_up && !link_rst, "R6 next check accepted", int'({link_up, link_rst}), 2);
        for (int i = 0; i < 4; i++) begin
            int n;
            n = int'($urandom_range(1, TRIES*TRIES));
            recover(n, i[0], 1'b0, "random recovery");
        end

        // R7/R8: directed threshold corners.
        fault_check(32'd250, 32'd0, "R7 lf rise of exactly 250 not flagged");
        fault_check(32'd501, 32'd0, "R7 lf rise of 251 flagged");
        fault_check(32'd502, 32'd0, "R8 capture after flag, small rise clears");
        fault_check(32'd502, 32'd300, "R7 rf rise flagged alone");
        fault_check(32'hFFFF_FFF0, 32'd300, "R7 lf big jump");
        fault_check(32'hFFFF_FFFF, 32'd300, "R7 wrapped sum compare");
        fault_check(32'd10, 32'd10, "R8 values captured every check");
        // R7/R8: random deltas around the threshold.
        for (int i = 0; i < 40; i++) begin
            logic [31:0] dl;
            logic [31:0] dr;
            dl = $urandom_range(0, 600);
            dr = $urandom_range(0, 600);
            fault_check(last_lf + dl, last_rf + dr, "R7 R8 random deltas");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule